// File: doc/BRIEF.md
# Set-Associative Branch Target Array

This block is the fetch-side table that says whether the instruction at a given address is a branch, where it is expected to go, and what kind of branch it is. Fetch presents an instruction address every cycle. One cycle later the block reports a hit flag, the predicted target and a two-bit branch class. It also gives two decoded flags. One tells the front end to ask the direction predictor. The other tells it to redirect straight to the stored target.

The table is set-associative and built from registers. The low address bits above the instruction offset select a set. Only a short slice of the address above the index is kept as a tag. Two branches that share that slice alias to one entry. A false hit of this kind can only cost a misprediction, never wrong execution.

The execute stage writes the table when it resolves a branch. If the branch already has an entry in its set, that entry is refreshed in place. Otherwise a way is allocated. An empty way is used first. When the set is full, a per-set round-robin pointer picks the victim. Fetch lookups never change the table.

Top module: `bta_top`

## Requirements
- R1: While reset is high, and in the cycle after it is released, lk_hit, lk_target, lk_type, lk_need_dir and lk_take_tgt are all zero.
- R2: The lookup result is registered. A valid entry whose set and tag match the address given in cycle t reports lk_hit=1 with its stored target and type in cycle t+1.
- R3: A write and a lookup in the same cycle return the table contents from before the write. The written entry is visible to a lookup made in the next cycle.
- R4: The set index is address bits [8:2] and the partial tag is bits [16:9]. Bits [1:0] and [31:17] take no part in the match, so addresses that differ only there hit the same entry.
- R5: A lookup whose set has no valid entry with a matching tag misses. This covers a different index with an equal tag, and an equal index with a different tag.
- R6: A write whose tag matches a valid entry in its set overwrites that entry's target and type in place. It does not take another way and does not move the round-robin pointer.
- R7: A write that matches no entry allocates the lowest-numbered invalid way. If all ways are valid, it replaces the way named by that set's round-robin pointer. The pointer advances by one, wrapping at the way count, on every allocation.
- R8: Type codes are 00 conditional, 01 return, 10 call and 11 unconditional. On a hit, lk_need_dir is 1 only for code 00, and lk_take_tgt is 1 for every other code.
- R9: On a miss, lk_target, lk_type, lk_need_dir and lk_take_tgt are zero.
- R10: Reset invalidates every entry and returns every round-robin pointer to way 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_addr | input | 32 | Fetch lookup address |
| lk_hit | output | 1 | Registered: the looked-up address is a known branch |
| lk_target | output | 32 | Registered predicted target |
| lk_type | output | 2 | Registered branch class code |
| lk_need_dir | output | 1 | Registered: hit on a conditional branch |
| lk_take_tgt | output | 1 | Registered: hit on a branch whose target is used directly |
| wr_en | input | 1 | Resolve write strobe |
| wr_addr | input | 32 | Address of the resolved branch |
| wr_target | input | 32 | Resolved target |
| wr_type | input | 2 | Resolved branch class code |

## Verification
The assertions assume that every input is a known value on every clock edge outside reset. They also assume the execute stage offers at most one resolved branch per cycle, and that the set count is a power of two so every index selects a real set. The write-visibility property depends on this. Only one write can land per edge, so no later write in the same cycle can displace the entry before the following lookup reads it. The bench drives every input on the falling edge with fully defined addresses. It presents at most one write per step and keeps the default geometry. Its random phase confines addresses to a few sets and tags, so that aliasing, refresh and eviction happen often.

// File: rtl/bta_pkg.sv
package bta_pkg;
  typedef enum logic [1:0] {
    BT_COND = 2'b00,
    BT_RET  = 2'b01,
    BT_CALL = 2'b10,
    BT_JMP  = 2'b11
  } btype_e;
endpackage

// File: rtl/bta_way_store.sv
// One way of the table: valid bits with reset, payload arrays without.
module bta_way_store #(
  parameter int SETS  = 128,
  parameter int IDX_W = 7,
  parameter int TAG_W = 8,
  parameter int TGT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  output logic [TGT_W-1:0] rd_tgt,
  output logic [1:0]       rd_typ,
  input  logic [IDX_W-1:0] pr_idx,
  output logic             pr_valid,
  output logic [TAG_W-1:0] pr_tag,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [TGT_W-1:0] wr_tgt,
  input  logic [1:0]       wr_typ
);
  logic [SETS-1:0]  vld;
  logic [TAG_W-1:0] tags [SETS];
  logic [TGT_W-1:0] tgts [SETS];
  logic [1:0]       typs [SETS];

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else if (we) vld[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (we) begin
      tags[wr_idx] <= wr_tag;
      tgts[wr_idx] <= wr_tgt;
      typs[wr_idx] <= wr_typ;
    end
  end

  assign rd_valid = vld[rd_idx];
  assign rd_tag   = tags[rd_idx];
  assign rd_tgt   = tgts[rd_idx];
  assign rd_typ   = typs[rd_idx];
  assign pr_valid = vld[pr_idx];
  assign pr_tag   = tags[pr_idx];
endmodule

// File: rtl/bta_victim.sv
// Way choice for a write: matching way, else lowest free way, else pointer.
module bta_victim #(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0]  match,
  input  logic [WAYS-1:0]  valid,
  input  logic [WAY_W-1:0] rr,
  output logic [WAY_W-1:0] way,
  output logic             alloc
);
  logic found_m, found_f;

  always_comb begin
    way     = rr;
    alloc   = 1'b1;
    found_m = 1'b0;
    found_f = 1'b0;
    for (int i = 0; i < WAYS; i++) begin
      if (!found_m && match[i]) begin
        way     = WAY_W'(i);
        found_m = 1'b1;
        alloc   = 1'b0;
      end
    end
    if (!found_m) begin
      for (int i = 0; i < WAYS; i++) begin
        if (!found_f && !valid[i]) begin
          way     = WAY_W'(i);
          found_f = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bta_rr_ptr.sv
// Per-set round-robin replacement pointers.
module bta_rr_ptr #(
  parameter int SETS  = 128,
  parameter int IDX_W = 7,
  parameter int WAYS  = 4,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  input  logic             adv,
  output logic [WAY_W-1:0] ptr
);
  localparam logic [WAY_W-1:0] LAST = WAY_W'(WAYS - 1);
  logic [WAY_W-1:0] ptrs [SETS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) ptrs[s] <= '0;
    end else if (adv) begin
      ptrs[idx] <= (ptrs[idx] == LAST) ? '0 : ptrs[idx] + 1'b1;
    end
  end

  assign ptr = ptrs[idx];
endmodule

// File: rtl/bta_top.sv
module bta_top #(
  parameter int ADDR_W = 32,
  parameter int TGT_W  = 32,
  parameter int SETS   = 128,
  parameter int WAYS   = 4,
  parameter int TAG_W  = 8,
  parameter int OFF_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [TGT_W-1:0]  lk_target,
  output logic [1:0]        lk_type,
  output logic              lk_need_dir,
  output logic              lk_take_tgt,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [TGT_W-1:0]  wr_target,
  input  logic [1:0]        wr_type
);
  import bta_pkg::*;

  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int TAG_LO = OFF_W + IDX_W;
  localparam int HI_LO  = TAG_LO + TAG_W;

  logic [IDX_W-1:0] lk_idx, wr_idx;
  logic [TAG_W-1:0] lk_tag, wr_tag;
  logic             wr_go;

  assign lk_idx = lk_addr[OFF_W +: IDX_W];
  assign lk_tag = lk_addr[TAG_LO +: TAG_W];
  assign wr_idx = wr_addr[OFF_W +: IDX_W];
  assign wr_tag = wr_addr[TAG_LO +: TAG_W];
  assign wr_go  = wr_en && !rst;

  logic unused_addr_bits;
  assign unused_addr_bits = ^{lk_addr[OFF_W-1:0], lk_addr[ADDR_W-1:HI_LO],
                              wr_addr[OFF_W-1:0], wr_addr[ADDR_W-1:HI_LO]};

  logic             rd_valid [WAYS];
  logic [TAG_W-1:0] rd_tag   [WAYS];
  logic [TGT_W-1:0] rd_tgt   [WAYS];
  logic [1:0]       rd_typ   [WAYS];
  logic             pr_valid [WAYS];
  logic [TAG_W-1:0] pr_tag   [WAYS];
  logic [WAYS-1:0]  lk_match, wr_match, wr_valid;
  logic [WAY_W-1:0] sel_way, rr_way;
  logic             alloc;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    bta_way_store #(
      .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .TGT_W(TGT_W)
    ) u_store (
      .clk     (clk),
      .rst     (rst),
      .rd_idx  (lk_idx),
      .rd_valid(rd_valid[w]),
      .rd_tag  (rd_tag[w]),
      .rd_tgt  (rd_tgt[w]),
      .rd_typ  (rd_typ[w]),
      .pr_idx  (wr_idx),
      .pr_valid(pr_valid[w]),
      .pr_tag  (pr_tag[w]),
      .we      (wr_go && (sel_way == WAY_W'(w))),
      .wr_idx  (wr_idx),
      .wr_tag  (wr_tag),
      .wr_tgt  (wr_target),
      .wr_typ  (wr_type)
    );
    assign lk_match[w] = rd_valid[w] && (rd_tag[w] == lk_tag);
    assign wr_match[w] = pr_valid[w] && (pr_tag[w] == wr_tag);
    assign wr_valid[w] = pr_valid[w];
  end

  bta_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
    .match(wr_match),
    .valid(wr_valid),
    .rr   (rr_way),
    .way  (sel_way),
    .alloc(alloc)
  );

  bta_rr_ptr #(.SETS(SETS), .IDX_W(IDX_W), .WAYS(WAYS), .WAY_W(WAY_W)) u_rr (
    .clk(clk),
    .rst(rst),
    .idx(wr_idx),
    .adv(wr_go && alloc),
    .ptr(rr_way)
  );

  // Lookup: lowest matching way wins; zeros on a miss.
  logic             hit_c, found;
  logic [TGT_W-1:0] tgt_c;
  logic [1:0]       typ_c;

  always_comb begin
    hit_c = 1'b0;
    tgt_c = '0;
    typ_c = '0;
    found = 1'b0;
    for (int i = 0; i < WAYS; i++) begin
      if (!found && lk_match[i]) begin
        found = 1'b1;
        hit_c = 1'b1;
        tgt_c = rd_tgt[i];
        typ_c = rd_typ[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_hit      <= 1'b0;
      lk_target   <= '0;
      lk_type     <= '0;
      lk_need_dir <= 1'b0;
      lk_take_tgt <= 1'b0;
    end else begin
      lk_hit      <= hit_c;
      lk_target   <= tgt_c;
      lk_type     <= typ_c;
      lk_need_dir <= hit_c && (btype_e'(typ_c) == BT_COND);
      lk_take_tgt <= hit_c && (btype_e'(typ_c) != BT_COND);
    end
  end
endmodule

// File: rtl/bta_top_chk.sv
module bta_top_chk #(
  parameter int ADDR_W = 32,
  parameter int TGT_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] lk_addr,
  input logic              lk_hit,
  input logic [TGT_W-1:0]  lk_target,
  input logic [1:0]        lk_type,
  input logic              lk_need_dir,
  input logic              lk_take_tgt,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [TGT_W-1:0]  wr_target,
  input logic [1:0]        wr_type
);
  logic              w_q;
  logic [ADDR_W-1:0] wa_q;
  logic [TGT_W-1:0]  wt_q;
  logic [1:0]        wy_q;

  always_ff @(posedge clk) begin
    w_q  <= wr_en && !rst;
    wa_q <= wr_addr;
    wt_q <= wr_target;
    wy_q <= wr_type;
  end

  // R1: reset forces a miss on the following cycle
  a_r1_reset_miss: assert property (@(posedge clk) rst |=> !lk_hit);

  // R3: a written branch hits when looked up in the cycle after the write
  a_r3_write_visible: assert property (@(posedge clk) disable iff (rst)
    (w_q && lk_addr == wa_q) |=>
      (lk_hit && lk_target == $past(wt_q) && lk_type == $past(wy_q)));

  // R8: decoded flags agree with the registered class code
  a_r8_flag_decode: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> (lk_need_dir == (lk_type == 2'b00)) &&
               (lk_take_tgt == (lk_type != 2'b00)));

  // R8: at most one flag, and a flag exactly when hit
  a_r8_flags_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({lk_need_dir, lk_take_tgt}) &&
    (lk_hit == (lk_need_dir || lk_take_tgt)));

  // R9: quiet outputs on a miss
  a_r9_miss_zero: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> (lk_target == '0 && lk_type == 2'b00));
endmodule

bind bta_top bta_top_chk #(.ADDR_W(ADDR_W), .TGT_W(TGT_W)) u_chk (.*);

// File: tb/bta_top_bench.sv
`timescale 1ns/1ps
module bta_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] lk_addr = '0;
  logic        lk_hit;
  logic [31:0] lk_target;
  logic [1:0]  lk_type;
  logic        lk_need_dir, lk_take_tgt;
  logic        wr_en = 1'b0;
  logic [31:0] wr_addr = '0;
  logic [31:0] wr_target = '0;
  logic [1:0]  wr_type = '0;

  always #10 clk = ~clk;

  bta_top u_bta_top (.*);

  int nchk = 0;
  int nfail = 0;

  // reference model
  bit          mv   [128][4];
  logic [7:0]  mtag [128][4];
  logic [31:0] mtgt [128][4];
  logic [1:0]  mtyp [128][4];
  int          mrr  [128];

  // scoreboard queues
  bit          qh [$];
  logic [31:0] qt [$];
  logic [1:0]  qy [$];
  string       qr [$];

  function automatic logic [31:0] mk(input int set, input int tag, input int hi);
    return {15'(hi), 8'(tag), 7'(set), 2'b00};
  endfunction

  task automatic model_clear();
    for (int s = 0; s < 128; s++) begin
      mrr[s] = 0;
      for (int w = 0; w < 4; w++) mv[s][w] = 1'b0;
    end
  endtask

  task automatic model_look(input logic [31:0] a, output bit h,
                            output logic [31:0] t, output logic [1:0] y);
    int s = int'(a[8:2]);
    h = 1'b0; t = '0; y = '0;
    for (int w = 3; w >= 0; w--)
      if (mv[s][w] && mtag[s][w] == a[16:9]) begin
        h = 1'b1; t = mtgt[s][w]; y = mtyp[s][w];
      end
  endtask

  task automatic model_write(input logic [31:0] a, input logic [31:0] t, input logic [1:0] y);
    int s = int'(a[8:2]);
    int way = -1;
    for (int w = 3; w >= 0; w--) if (mv[s][w] && mtag[s][w] == a[16:9]) way = w;
    if (way < 0) begin
      for (int w = 3; w >= 0; w--) if (!mv[s][w]) way = w;
      if (way < 0) way = mrr[s];
      mrr[s] = (mrr[s] + 1) % 4;
    end
    mv[s][way] = 1'b1; mtag[s][way] = a[16:9]; mtgt[s][way] = t; mtyp[s][way] = y;
  endtask

  task automatic step(input logic [31:0] la, input bit we, input logic [31:0] wa,
                      input logic [31:0] wt, input logic [1:0] wy,
                      input bit chk, input string req);
    bit h; logic [31:0] t; logic [1:0] y;
    @(negedge clk);
    lk_addr = la; wr_en = we; wr_addr = wa; wr_target = wt; wr_type = wy;
    if (chk) begin
      model_look(la, h, t, y);
      qh.push_back(h); qt.push_back(t); qy.push_back(y); qr.push_back(req);
    end
    if (we) model_write(wa, wt, wy);
  endtask

  task automatic look(input logic [31:0] la, input string req);
    step(la, 1'b0, '0, '0, 2'b00, 1'b1, req);
  endtask

  task automatic put(input logic [31:0] wa, input logic [31:0] wt, input logic [1:0] wy);
    step('0, 1'b1, wa, wt, wy, 1'b0, "");
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step('0, 1'b0, '0, '0, 2'b00, 1'b0, "");
  endtask

  // monitor: compares one cycle after each checked lookup
  always @(posedge clk) begin
    bit eh; logic [31:0] et; logic [1:0] ey; string er;
    bit en, ek;
    #2;
    if (qh.size() > 0) begin
      eh = qh.pop_front(); et = qt.pop_front(); ey = qy.pop_front(); er = qr.pop_front();
      en = eh && (ey == 2'b00);
      ek = eh && (ey != 2'b00);
      nchk++;
      if (lk_hit !== eh || lk_target !== et || lk_type !== ey ||
          lk_need_dir !== en || lk_take_tgt !== ek) begin
        nfail++;
        $display("FAIL %s: got hit=%0b tgt=%h typ=%0d nd=%0b tk=%0b exp hit=%0b tgt=%h typ=%0d nd=%0b tk=%0b",
                 er, lk_hit, lk_target, lk_type, lk_need_dir, lk_take_tgt, eh, et, ey, en, ek);
      end
    end
  end

  task automatic direct_zero(input string req);
    nchk++;
    if (lk_hit !== 1'b0 || lk_target !== '0 || lk_type !== 2'b00 ||
        lk_need_dir !== 1'b0 || lk_take_tgt !== 1'b0) begin
      nfail++;
      $display("FAIL %s: got hit=%0b tgt=%h typ=%0d exp all zero", req, lk_hit, lk_target, lk_type);
    end
  endtask

  task automatic do_reset();
    idle(3);
    @(negedge clk); rst = 1'b1; wr_en = 1'b0;
    @(posedge clk); #2; direct_zero("R1 during reset");
    @(negedge clk); rst = 1'b0;
    model_clear();
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    nfail++;
    $display("FAIL watchdog: run did not end, exp completion");
    summary();
  end

  initial begin
    logic [31:0] a;
    model_clear();
    repeat (3) @(posedge clk);
    #2; direct_zero("R1 in reset");
    @(negedge clk); rst = 1'b0;

    // R1 / R9: empty table misses with quiet outputs
    look(mk(5, 3, 0), "R1");
    look(mk(0, 0, 0), "R9");

    // R3 then R2: write and same-cycle lookup see old contents
    a = mk(5, 3, 0);
    step(a, 1'b1, a, 32'h0000_1000, 2'b11, 1'b1, "R3");
    look(a, "R2");
    look(a, "R3");

    // R4: ignored address bits still hit
    look(mk(5, 3, 7), "R4");
    look(a | 32'h1, "R4");
    look(mk(5, 3, 16'h7fff), "R4");

    // R5: other set or other tag misses
    look(mk(6, 3, 0), "R5");
    look(mk(5, 4, 0), "R5");

    // R8: every class code in one set
    for (int y = 0; y < 4; y++) put(mk(20, 10 + y, 0), 32'h2000 + 32'(y), 2'(y));
    for (int y = 0; y < 4; y++) look(mk(20, 10 + y, 0), "R8");

    // R7: free ways first, then round-robin victims
    for (int g = 1; g <= 4; g++) put(mk(40, g, 0), 32'h4000 + 32'(g), 2'b10);
    for (int g = 1; g <= 4; g++) look(mk(40, g, 0), "R7");
    put(mk(40, 5, 0), 32'h4005, 2'b01);
    for (int g = 1; g <= 5; g++) look(mk(40, g, 0), "R7");
    put(mk(40, 6, 0), 32'h4006, 2'b00);
    for (int g = 1; g <= 6; g++) look(mk(40, g, 0), "R7");

    // R6: refresh in place does not consume a way or move the pointer
    for (int g = 1; g <= 4; g++) put(mk(60, g, 0), 32'h6000 + 32'(g), 2'b11);
    put(mk(60, 2, 0), 32'h6222, 2'b00);
    look(mk(60, 2, 0), "R6");
    put(mk(60, 9, 0), 32'h6009, 2'b11);
    for (int g = 1; g <= 4; g++) look(mk(60, g, 0), "R6");
    look(mk(60, 9, 0), "R6");
    put(mk(61, 1, 0), 32'h6101, 2'b11);
    put(mk(61, 1, 0), 32'h6102, 2'b10);
    put(mk(61, 1, 0), 32'h6103, 2'b01);
    for (int g = 2; g <= 4; g++) put(mk(61, g, 0), 32'h6100 + 32'(g), 2'b11);
    for (int g = 1; g <= 4; g++) look(mk(61, g, 0), "R6");

    // R10: reset empties the table and rewinds the pointers
    do_reset();
    look(mk(5, 3, 0), "R10");
    look(mk(40, 5, 0), "R10");
    look(mk(61, 1, 0), "R10");
    for (int g = 1; g <= 5; g++) put(mk(40, g, 0), 32'h7000 + 32'(g), 2'b11);
    for (int g = 1; g <= 5; g++) look(mk(40, g, 0), "R10");

    // R2: mixed traffic over a few crowded sets
    for (int i = 0; i < 400; i++) begin
      logic [31:0] la, wa;
      la = mk(100 + int'($urandom % 3), int'($urandom % 6), int'($urandom % 3));
      wa = mk(100 + int'($urandom % 3), int'($urandom % 6), int'($urandom % 3));
      step(la, 1'($urandom % 2), wa, $urandom, 2'($urandom % 4), 1'b1, "R2");
    end

    idle(4);
    summary();
  end
endmodule